// File: doc/BRIEF.md
# PCM-30 Receive Frame Aligner

This block sits behind the line decoder of a 2.048 Mbit/s receive path. It takes the recovered serial data and the route clock extracted from it, and finds the 256-bit frame boundary. The search runs one bit at a time over the incoming stream. A candidate boundary is confirmed over three frames before the block reports alignment. Once aligned, the block checks every alternate frame for the alignment word and keeps a slot and bit counter locked to the boundary, so that downstream logic can pick out time slots.

The block has two event outputs. A one-cycle sync marker flags the last bit before time slot zero of each frame that carries the alignment word, and only while aligned. A four-cycle fault pulse reports each bad alignment word that arrives while aligned. While alignment is absent, the same fault pulse repeats once every two frames.

Top module: `pcm30_frame_aligner`

## Requirements
- R1: While rst_ni is low, in_frame_o, sync_o and fault_o are 0, and slot_o and bit_o are 0.
- R2: During the search, the block finds the 7-bit word 0011011 in the stream (first received bit on the left). On the bit that completes it, the counters are set so that the completing bit reads as slot 0, bit 7. That bit is also tagged as part of a word-carrying frame.
- R3: in_frame_o rises on the edge that samples bit 7 of slot 0 in the second word-carrying frame after the search hit. This needs the alignment word in bit positions 1 to 7 of that slot, and the bit at position 1 of slot 0 in the frame between them must have been 1.
- R4: If the bit at position 1 of slot 0 in the frame after a search hit is 0, the block returns to the search, and in_frame_o stays 0.
- R5: On every clock that does not load a search hit, the position {slot_o, bit_o} advances by one. After slot 31, bit 7 it wraps to slot 0, bit 0, and the frame type flips between word-carrying and not.
- R6: While aligned, sync_o is 1 for exactly the one cycle in which the counters show slot 31, bit 7 of a frame that precedes a word-carrying frame. It is 0 on all other cycles.
- R7: sync_o stays 0 for as long as in_frame_o is 0.
- R8: While aligned, each word-carrying frame whose bits 1 to 7 of slot 0 differ from 0011011 starts a fault pulse. fault_o is 1 for exactly the 4 cycles after the edge that samples bit 7.
- R9: Alignment drops (in_frame_o falls) on the third bad alignment word in a row. A correct word resets the run of errors. After the drop, the bit-by-bit search restarts.
- R10: While in_frame_o is 0, a 4-cycle fault pulse starts after each cycle in which the counters show slot 31, bit 7 of a frame that is not word-carrying. With a steady search, this is once every 512 clocks.
- R11: The bit that arrives first in each 8-bit slot is bit position 0. Bit position 0 of slot 0 is not checked in any frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Route clock recovered from the line, 2.048 MHz |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 1 | Serial PCM data, sampled on the rising edge |
| sync_o | output | 1 | Marks the bit before slot 0 of word-carrying frames while aligned |
| fault_o | output | 1 | Four-cycle fault pulse |
| in_frame_o | output | 1 | Frame alignment held |
| slot_o | output | 5 | Time slot of the last sampled bit |
| bit_o | output | 3 | Bit position within the slot of the last sampled bit |

## Verification
The bench takes aim at the error run. It sends two bad words, then a good one, then two more bad ones, and expects alignment to hold. A design that never cleared its error count would drop alignment there. With the alignment word removed entirely, it checks that alignment falls and that fault pulses then arrive exactly four times in 2048 clocks with no sync marker. A design that pulsed every frame, or that let the marker through, fails this. It holds position 1 of the non-word frame at 0 to show that a hit without confirmation never declares alignment. It also compares the counters against the transmit position, which catches an off-by-one when a search hit is loaded. A final phase with random payload checks that false words in the data neither break a held alignment nor lead to a spurious one.

// File: rtl/pcm30_pkg.sv
package pcm30_pkg;
  typedef enum logic [1:0] {
    ST_HUNT     = 2'd0,
    ST_CHK_NFAS = 2'd1,
    ST_CHK_FAS  = 2'd2,
    ST_SYNC     = 2'd3
  } align_st_e;

  localparam int unsigned ALIGN_WORD_LEN = 7;
  localparam logic [ALIGN_WORD_LEN-1:0] ALIGN_WORD = 7'b0011011;
endpackage

// File: rtl/pcm30_word_window.sv
module pcm30_word_window #(
  parameter int unsigned WIN = 7,
  parameter logic [WIN-1:0] PATTERN = 7'b0011011
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  output logic match_o
);
  logic [WIN-2:0] hist_q;
  logic [WIN-1:0] window;

  // oldest bit on the left
  assign window  = {hist_q, data_i};
  assign match_o = (window == PATTERN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= window[WIN-2:0];
  end
endmodule

// File: rtl/pcm30_frame_timer.sv
module pcm30_frame_timer #(
  parameter int unsigned FRAME_BITS = 256,
  parameter int unsigned LOAD_POS   = 7,
  localparam int unsigned POS_W     = $clog2(FRAME_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  output logic [POS_W-1:0] pos_o,
  output logic             fas_o,
  output logic [POS_W-1:0] pos_nx_o,
  output logic             fas_nx_o
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] LPOS = POS_W'(LOAD_POS);

  logic [POS_W-1:0] pos_q;
  logic             fas_q;

  assign pos_nx_o = (pos_q == LAST) ? '0 : pos_q + 1'b1;
  assign fas_nx_o = (pos_q == LAST) ? ~fas_q : fas_q;
  assign pos_o    = pos_q;
  assign fas_o    = fas_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      fas_q <= 1'b0;
    end else if (load_i) begin
      pos_q <= LPOS;
      fas_q <= 1'b1;
    end else begin
      pos_q <= pos_nx_o;
      fas_q <= fas_nx_o;
    end
  end

  assert_wrap_flip_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q == LAST && !load_i) |=> (pos_q == '0 && fas_q != $past(fas_q)));

  assert_load_pos_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (pos_q == LPOS && fas_q));
endmodule

// File: rtl/pcm30_align_fsm.sv
module pcm30_align_fsm
  import pcm30_pkg::*;
#(
  parameter int unsigned POS_W      = 8,
  parameter int unsigned NFAS_POS   = 1,
  parameter int unsigned CHK_POS    = 7,
  parameter int unsigned LAST_POS   = 255,
  parameter int unsigned LOSS_LIMIT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_i,
  input  logic             match_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             fas_i,
  input  logic [POS_W-1:0] pos_nx_i,
  input  logic             fas_nx_i,
  output logic             load_o,
  output logic             in_frame_o,
  output logic             fas_err_o,
  output logic             lost_tick_o
);
  localparam int unsigned ERR_W = $clog2(LOSS_LIMIT + 1);
  localparam logic [ERR_W-1:0] ERR_LAST = ERR_W'(LOSS_LIMIT - 1);

  align_st_e        st_q, st_d;
  logic [ERR_W-1:0] err_q, err_d;
  logic             at_nfas, at_fas;

  assign at_nfas = (pos_nx_i == POS_W'(NFAS_POS)) && !fas_nx_i;
  assign at_fas  = (pos_nx_i == POS_W'(CHK_POS)) && fas_nx_i;

  always_comb begin
    st_d      = st_q;
    err_d     = err_q;
    load_o    = 1'b0;
    fas_err_o = 1'b0;
    unique case (st_q)
      ST_HUNT: begin
        if (match_i) begin
          load_o = 1'b1;
          st_d   = ST_CHK_NFAS;
        end
      end
      ST_CHK_NFAS: begin
        if (at_nfas) st_d = data_i ? ST_CHK_FAS : ST_HUNT;
      end
      ST_CHK_FAS: begin
        if (at_fas) begin
          st_d  = match_i ? ST_SYNC : ST_HUNT;
          err_d = '0;
        end
      end
      ST_SYNC: begin
        if (at_fas) begin
          if (match_i) begin
            err_d = '0;
          end else begin
            fas_err_o = 1'b1;
            if (err_q == ERR_LAST) begin
              st_d  = ST_HUNT;
              err_d = '0;
            end else begin
              err_d = err_q + 1'b1;
            end
          end
        end
      end
      default: st_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_HUNT;
      err_q <= '0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  assign in_frame_o  = (st_q == ST_SYNC);
  assign lost_tick_o = (st_q != ST_SYNC) && (pos_i == POS_W'(LAST_POS)) && !fas_i;

  assert_nfas_reject_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CHK_NFAS && at_nfas && !data_i) |=> (st_q == ST_HUNT));

  assert_lock_path_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_frame_o) |-> $past(st_q == ST_CHK_FAS && match_i));

  assert_loss_on_error_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_frame_o) |-> $past(fas_err_o));

  assert_err_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q < ERR_W'(LOSS_LIMIT));
endmodule

// File: rtl/pcm30_pulse_stretch.sv
module pcm30_pulse_stretch #(
  parameter int unsigned LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int unsigned CNT_W = $clog2(LEN + 1);
  localparam int unsigned RUN_W = $clog2(LEN + 2);

  logic [CNT_W-1:0] cnt_q;
  logic [RUN_W-1:0] run_q;

  assign pulse_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (trig_i)  cnt_q <= CNT_W'(LEN);
    else if (pulse_o) cnt_q <= cnt_q - 1'b1;
  end

  // checker: high cycles since last trigger
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              run_q <= '0;
    else if (trig_i)                          run_q <= RUN_W'(1);
    else if (pulse_o && run_q <= RUN_W'(LEN)) run_q <= run_q + 1'b1;
  end

  assert_trig_starts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> pulse_o);

  assert_rise_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> $past(trig_i));

  assert_len_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> (run_q <= RUN_W'(LEN)));
endmodule

// File: rtl/pcm30_frame_aligner.sv
module pcm30_frame_aligner
  import pcm30_pkg::*;
#(
  parameter int unsigned SLOT_BITS  = 8,
  parameter int unsigned SLOTS      = 32,
  parameter int unsigned LOSS_LIMIT = 3,
  parameter int unsigned FAULT_LEN  = 4,
  localparam int unsigned FRAME_BITS = SLOT_BITS * SLOTS,
  localparam int unsigned POS_W      = $clog2(FRAME_BITS),
  localparam int unsigned BIT_W      = $clog2(SLOT_BITS),
  localparam int unsigned SLOT_W     = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              data_i,
  output logic              sync_o,
  output logic              fault_o,
  output logic              in_frame_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [BIT_W-1:0]  bit_o
);
  localparam int unsigned CHK_POS  = SLOT_BITS - 1;
  localparam int unsigned NFAS_POS = SLOT_BITS - ALIGN_WORD_LEN;
  localparam int unsigned LAST_POS = FRAME_BITS - 1;

  logic             match, load, fas, fas_nx, fas_err, lost_tick;
  logic [POS_W-1:0] pos, pos_nx;

  pcm30_word_window #(
    .WIN     (ALIGN_WORD_LEN),
    .PATTERN (ALIGN_WORD)
  ) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .data_i  (data_i),
    .match_o (match)
  );

  pcm30_frame_timer #(
    .FRAME_BITS (FRAME_BITS),
    .LOAD_POS   (CHK_POS)
  ) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .pos_o    (pos),
    .fas_o    (fas),
    .pos_nx_o (pos_nx),
    .fas_nx_o (fas_nx)
  );

  pcm30_align_fsm #(
    .POS_W      (POS_W),
    .NFAS_POS   (NFAS_POS),
    .CHK_POS    (CHK_POS),
    .LAST_POS   (LAST_POS),
    .LOSS_LIMIT (LOSS_LIMIT)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .data_i      (data_i),
    .match_i     (match),
    .pos_i       (pos),
    .fas_i       (fas),
    .pos_nx_i    (pos_nx),
    .fas_nx_i    (fas_nx),
    .load_o      (load),
    .in_frame_o  (in_frame_o),
    .fas_err_o   (fas_err),
    .lost_tick_o (lost_tick)
  );

  pcm30_pulse_stretch #(
    .LEN (FAULT_LEN)
  ) u_fault (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (fas_err | lost_tick),
    .pulse_o (fault_o)
  );

  assign sync_o = in_frame_o && (pos == POS_W'(LAST_POS)) && !fas;
  assign slot_o = pos[POS_W-1:BIT_W];
  assign bit_o  = pos[BIT_W-1:0];

  assert_sync_lands_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_o && !load) |=> (slot_o == '0 && bit_o == '0));

  assert_sync_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> !sync_o);
endmodule

// File: tb/sim_pcm30_frame_aligner.sv
module sim_pcm30_frame_aligner;
  localparam int FB = 256;
  localparam logic [6:0] WORD = 7'b0011011;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       data = 1'b1;
  logic       sync_w, fault_w, inf_w;
  logic [4:0] slot_w;
  logic [2:0] bit_w;

  pcm30_frame_aligner u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .data_i     (data),
    .sync_o     (sync_w),
    .fault_o    (fault_w),
    .in_frame_o (inf_w),
    .slot_o     (slot_w),
    .bit_o      (bit_w)
  );

  always #4 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- stimulus generator ----------------
  int tx_pos = 100;
  bit tx_fas = 1'b0;
  int last_pos = 0;
  bit no_word = 0, nfas_zero = 0, rand_mode = 0;
  bit cur_bad = 0;
  bit bad_plan[$];

  function automatic logic gen_bit(int p, bit f);
    if (p < 8) begin
      if (f) begin
        if (no_word || p == 0) return 1'b1;
        if (cur_bad && p == 4) return ~WORD[7-p];
        return WORD[7-p];
      end
      if (p == 1) return nfas_zero ? 1'b0 : 1'b1;
    end
    return rand_mode ? 1'($urandom % 2) : 1'b1;
  endfunction

  // ---------------- reference model ----------------
  int m_st = 0, m_pos = 0, m_err = 0, m_fcnt = 0;
  bit m_fas = 0;
  bit m_hist[$];

  task automatic model_reset();
    m_st = 0; m_pos = 0; m_err = 0; m_fcnt = 0; m_fas = 0;
    m_hist.delete();
    for (int i = 0; i < 6; i++) m_hist.push_back(1'b0);
  endtask

  task automatic model_step(input bit d);
    int p; bit nf, hit, trig;
    p  = (m_pos + 1) % FB;
    nf = (p == 0) ? !m_fas : m_fas;
    m_hist.push_back(d);
    if (m_hist.size() > 7) void'(m_hist.pop_front());
    hit = 1;
    for (int i = 0; i < 7; i++) if (m_hist[i] != WORD[6-i]) hit = 0;
    trig = (m_st != 3 && m_pos == FB - 1 && !m_fas);
    if (m_st == 0) begin
      if (hit) begin m_pos = 7; m_fas = 1; m_st = 1; end
      else begin m_pos = p; m_fas = nf; end
    end else begin
      m_pos = p; m_fas = nf;
      if (m_st == 1) begin
        if (p == 1 && !nf) m_st = d ? 2 : 0;
      end else if (m_st == 2) begin
        if (p == 7 && nf) begin m_st = hit ? 3 : 0; m_err = 0; end
      end else begin
        if (p == 7 && nf) begin
          if (hit) m_err = 0;
          else begin
            trig = 1; m_err++;
            if (m_err == 3) begin m_st = 0; m_err = 0; end
          end
        end
      end
    end
    if (trig) m_fcnt = 4;
    else if (m_fcnt > 0) m_fcnt--;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step(data);
  end

  // ---------------- compare, monitor, drive ----------------
  int fault_cyc = 0, fault_rise = 0, sync_cnt = 0, inf_cyc = 0;
  bit fault_prev = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(inf_w == (m_st == 3), "R3 in_frame vs model", inf_w, m_st == 3);
      chk(sync_w == (m_st == 3 && m_pos == FB - 1 && !m_fas), "R6 sync vs model",
          sync_w, m_st == 3 && m_pos == FB - 1 && !m_fas);
      chk(fault_w == (m_fcnt > 0), "R10 fault vs model", fault_w, m_fcnt > 0);
      chk({slot_w, bit_w} == 8'(m_pos), "R5 counters vs model", {slot_w, bit_w}, m_pos);
      if (fault_w) fault_cyc++;
      if (fault_w && !fault_prev) fault_rise++;
      if (sync_w) sync_cnt++;
      if (inf_w) inf_cyc++;
      fault_prev = fault_w;
    end
    if (rst_n) begin
      if (tx_pos == 0 && tx_fas) cur_bad = (bad_plan.size() > 0) ? bad_plan.pop_front() : 1'b0;
      data = gen_bit(tx_pos, tx_fas);
      last_pos = tx_pos;
      tx_pos = tx_pos + 1;
      if (tx_pos == FB) begin tx_pos = 0; tx_fas = !tx_fas; end
    end
  end

  task automatic clr();
    fault_cyc = 0; fault_rise = 0; sync_cnt = 0; inf_cyc = 0;
  endtask

  task automatic wait_frames(input int n);
    repeat (n * FB) @(posedge clk);
    #2;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- scenario ----------------
  initial begin
    #30;
    // R1 reset state
    chk(!inf_w && !sync_w && !fault_w, "R1 flags in reset", {inf_w, sync_w, fault_w}, 0);
    chk(slot_w == 0 && bit_w == 0, "R1 counters in reset", {slot_w, bit_w}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;

    // R2 R3 R11: lock on clean stream from an arbitrary offset
    wait_frames(8);
    chk(inf_w == 1, "R3 locked on clean stream", inf_w, 1);
    chk({slot_w, bit_w} == 8'(last_pos), "R2 counters track boundary", {slot_w, bit_w}, last_pos);

    // R6 two sync markers in four aligned frames
    clr(); wait_frames(4);
    chk(sync_cnt == 2, "R6 sync count", sync_cnt, 2);

    // R8 single bad word
    bad_plan.push_back(1'b1);
    clr(); wait_frames(4);
    chk(fault_cyc == 4, "R8 fault length", fault_cyc, 4);
    chk(inf_w == 1, "R9 one error keeps alignment", inf_w, 1);

    // R9 run broken by a good word
    bad_plan.push_back(1'b1); bad_plan.push_back(1'b1); bad_plan.push_back(1'b0);
    bad_plan.push_back(1'b1); bad_plan.push_back(1'b1);
    clr(); wait_frames(12);
    chk(fault_cyc == 16, "R8 four error pulses", fault_cyc, 16);
    chk(inf_w == 1, "R9 good word resets error run", inf_w, 1);

    // R9 three in a row drops alignment
    no_word = 1;
    wait_frames(8);
    chk(inf_w == 0, "R9 loss after three errors", inf_w, 0);

    // R10 R7 behaviour while out of alignment
    clr(); wait_frames(8);
    chk(fault_rise == 4, "R10 pulses on alternate frames", fault_rise, 4);
    chk(fault_cyc == 16, "R10 pulse length", fault_cyc, 16);
    chk(sync_cnt == 0, "R7 no sync while lost", sync_cnt, 0);

    // R4 unconfirmed hits never align
    no_word = 0; nfas_zero = 1;
    wait_frames(2);
    clr(); wait_frames(8);
    chk(inf_cyc == 0, "R4 no alignment without confirm bit", inf_cyc, 0);
    chk(sync_cnt == 0, "R7 no sync during search", sync_cnt, 0);

    // R3 recovery
    nfas_zero = 0;
    wait_frames(6);
    chk(inf_w == 1, "R3 relock after search", inf_w, 1);

    // R9 R5 random payload keeps lock
    rand_mode = 1;
    wait_frames(20);
    chk(inf_w == 1, "R9 lock held under random payload", inf_w, 1);
    chk({slot_w, bit_w} == 8'(last_pos), "R5 counters under random payload", {slot_w, bit_w}, last_pos);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule